// File: doc/BRIEF.md
# Banked GPIO Controller with Interrupt Sensing

This block is a general-purpose I/O controller for 256 pins, arranged as 16 banks of 16 pins. Software reaches it through a plain 32-bit register bus: an address, a write strobe, write data and a combinational read data return. Each bank has its own set of registers. They hold output values, a per-pin access gate, output enables, input sampling enables and the interrupt configuration. They also report interrupt status as raw and masked views, and a write-one-to-clear register acknowledges edge events.

Pin inputs pass through a two-stage synchroniser before any sampling or detection. Each pin can be sensed by level or by edge. The active polarity is selectable, and a both-edge override applies to edge-sensed pins. The masked status of every bank is combined into a single parent interrupt line. Reset is asserted asynchronously and released in step with the clock.

Top module: `gpio_banked_ctrl`

## Requirements
- R1: Address bits [10:7] select the bank and bits [6:0] select the register. The register offsets are: value 0x00, gate 0x04, output enable 0x08, level select 0x0C, both-edge 0x10, polarity 0x14, interrupt enable 0x18, raw status 0x1C, pending 0x20, clear 0x24, sample enable 0x28. Bit k of a register maps to pin k of its bank, and bank b pin k is pin 16·b+k. Read bits 31:16 are always 0. Unmapped offsets read 0. A write to one bank leaves every other bank unchanged.
- R2: After reset every register is 0. No pin is driven, the interrupt line is low, and the status registers read 0.
- R3: pin_oe of a pin equals its output-enable bit, and pin_out equals its stored value bit. Both change only after a bus write.
- R4: A value write changes only pins whose gate bit is 1. A value read returns 0 for pins whose gate bit is 0.
- R5: A value read returns the stored bit for a gated output pin. For a gated input pin it returns the synchronised input when the sample-enable bit is 1, and 0 otherwise. A new input level is visible on the second clock edge after it is applied.
- R6: An edge-sensed pin (level bit 0, both-edge bit 0) latches raw status on a rising edge when its polarity bit is 1, and on a falling edge when the polarity bit is 0. Edges of the other direction do not latch.
- R7: With the both-edge bit set on an edge-sensed pin, both rising and falling edges latch raw status whatever the polarity bit holds.
- R8: A level-sensed pin (level bit 1) shows raw status while its synchronised input equals its polarity bit. A clear write has no lasting effect on it.
- R9: Writing 1 to a bit of the clear register drops that pin's latched edge status. Writing 0 leaves it set. The clear register reads 0.
- R10: The pending register is the raw status ANDed with the interrupt enable. irq is high exactly when any pending bit in any bank is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 11 | Byte address: bank in [10:7], register in [6:0] |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | 256 | Asynchronous pin inputs |
| pin_out | output | 256 | Output values |
| pin_oe | output | 256 | Output enables |
| irq | output | 1 | Combined parent interrupt |

## Verification
The hardest states to reach are those where a pin's edge history and its configuration interact. Examples are an edge of the wrong polarity arriving on an edge-sensed pin, a level-sensed pin that is cleared while its level stays active, and a pending bit in the last bank that alone must raise the parent line. The bench reaches them in three ways. It drives pin inputs from a held vector and waits out the synchroniser. It reprograms one register at a time and keeps track of each full-width value it has written. It reads raw and pending status in several banks between transitions, so that a stale or wrongly cleared latch is seen before the next stimulus.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [6:0] {
    OFF_VAL  = 7'h00,
    OFF_GATE = 7'h04,
    OFF_OEN  = 7'h08,
    OFF_LVL  = 7'h0C,
    OFF_BOTH = 7'h10,
    OFF_POL  = 7'h14,
    OFF_IEN  = 7'h18,
    OFF_RAW  = 7'h1C,
    OFF_PEND = 7'h20,
    OFF_CLR  = 7'h24,
    OFF_SAMP = 7'h28
  } reg_off_e;

  localparam int unsigned OFF_W = 7;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= d;
      hold_q <= meta_q;
    end
  end

  assign q = hold_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] off,
  input  logic [W-1:0]     wdata,
  input  logic [W-1:0]     pin_sync,
  output logic [W-1:0]     rdata,
  output logic [W-1:0]     pin_out,
  output logic [W-1:0]     pin_oe,
  output logic [W-1:0]     pend,
  output logic [W-1:0]     gate,
  output logic [W-1:0]     ien
);
  logic [W-1:0] val_q, gate_q, oen_q, lvl_q, both_q, pol_q, ien_q, samp_q, latch_q, prev_q;
  logic [W-1:0] val_d, gate_d, oen_d, lvl_d, both_d, pol_d, ien_d, samp_d, latch_d;
  logic [W-1:0] rise, fall, edge_hit, clr, raw, in_view;

  // edge and level detection
  always_comb begin
    rise     = pin_sync & ~prev_q;
    fall     = ~pin_sync & prev_q;
    edge_hit = (both_q & (rise | fall)) | (~both_q & ((pol_q & rise) | (~pol_q & fall)));
    clr      = (wr_en && off == OFF_CLR) ? wdata : '0;
    raw      = (lvl_q & ~(pin_sync ^ pol_q)) | (~lvl_q & latch_q);
    in_view  = gate_q & ((oen_q & val_q) | (~oen_q & samp_q & pin_sync));
  end

  // next state
  always_comb begin
    val_d   = val_q;
    gate_d  = gate_q;
    oen_d   = oen_q;
    lvl_d   = lvl_q;
    both_d  = both_q;
    pol_d   = pol_q;
    ien_d   = ien_q;
    samp_d  = samp_q;
    latch_d = (latch_q & ~clr) | (edge_hit & ~lvl_q);
    if (wr_en) begin
      case (off)
        OFF_VAL:  val_d  = (val_q & ~gate_q) | (wdata & gate_q);
        OFF_GATE: gate_d = wdata;
        OFF_OEN:  oen_d  = wdata;
        OFF_LVL:  lvl_d  = wdata;
        OFF_BOTH: both_d = wdata;
        OFF_POL:  pol_d  = wdata;
        OFF_IEN:  ien_d  = wdata;
        OFF_SAMP: samp_d = wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q   <= '0;
      gate_q  <= '0;
      oen_q   <= '0;
      lvl_q   <= '0;
      both_q  <= '0;
      pol_q   <= '0;
      ien_q   <= '0;
      samp_q  <= '0;
      latch_q <= '0;
      prev_q  <= '0;
    end else begin
      val_q   <= val_d;
      gate_q  <= gate_d;
      oen_q   <= oen_d;
      lvl_q   <= lvl_d;
      both_q  <= both_d;
      pol_q   <= pol_d;
      ien_q   <= ien_d;
      samp_q  <= samp_d;
      latch_q <= latch_d;
      prev_q  <= pin_sync;
    end
  end

  // read mux
  always_comb begin
    case (off)
      OFF_VAL:  rdata = in_view;
      OFF_GATE: rdata = gate_q;
      OFF_OEN:  rdata = oen_q;
      OFF_LVL:  rdata = lvl_q;
      OFF_BOTH: rdata = both_q;
      OFF_POL:  rdata = pol_q;
      OFF_IEN:  rdata = ien_q;
      OFF_RAW:  rdata = raw;
      OFF_PEND: rdata = raw & ien_q;
      OFF_SAMP: rdata = samp_q;
      default:  rdata = '0;
    endcase
  end

  assign pin_out = val_q;
  assign pin_oe  = oen_q;
  assign pend    = raw & ien_q;
  assign gate    = gate_q;
  assign ien     = ien_q;
endmodule

// File: rtl/gpio_banked_ctrl.sv
module gpio_banked_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned BANKS = 16,
  parameter int unsigned PPB   = 16,
  localparam int unsigned BW     = $clog2(BANKS),
  localparam int unsigned ADDR_W = BW + OFF_W,
  localparam int unsigned NPINS  = BANKS * PPB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  logic             rst_n_int;
  logic [NPINS-1:0] pin_sync, pend_all, gate_all, ien_all;
  logic [BW-1:0]    bank_idx;
  logic [OFF_W-1:0] off;
  logic [PPB-1:0]   rdata_arr [BANKS];
  logic [PPB-1:0]   rd_sel;
  logic             unused_hi;

  assign bank_idx  = bus_addr[ADDR_W-1:OFF_W];
  assign off       = bus_addr[OFF_W-1:0];
  assign unused_hi = ^bus_wdata[31:PPB];

  gpio_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  gpio_sync #(.W(NPINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d     (pin_in),
    .q     (pin_sync)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    gpio_bank #(.W(PPB)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n_int),
      .wr_en    (bus_we && (int'(bank_idx) == b)),
      .off      (off),
      .wdata    (bus_wdata[PPB-1:0]),
      .pin_sync (pin_sync[b*PPB +: PPB]),
      .rdata    (rdata_arr[b]),
      .pin_out  (pin_out[b*PPB +: PPB]),
      .pin_oe   (pin_oe[b*PPB +: PPB]),
      .pend     (pend_all[b*PPB +: PPB]),
      .gate     (gate_all[b*PPB +: PPB]),
      .ien      (ien_all[b*PPB +: PPB])
    );
  end

  always_comb begin
    rd_sel    = (int'(bank_idx) < BANKS) ? rdata_arr[bank_idx] : '0;
    bus_rdata = {{(32-PPB){1'b0}}, rd_sel};
    irq       = |pend_all;
  end
endmodule

// File: rtl/gpio_banked_ctrl_chk.sv
module gpio_banked_ctrl_chk
  import gpio_pkg::*;
#(
  parameter int unsigned BANKS = 16,
  parameter int unsigned PPB   = 16,
  localparam int unsigned ADDR_W = $clog2(BANKS) + OFF_W,
  localparam int unsigned NPINS  = BANKS * PPB
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_rdata,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pin_oe,
  input logic              irq,
  input logic [NPINS-1:0]  gate_all,
  input logic [NPINS-1:0]  ien_all
);
  AST_UPPER_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[31:PPB] == '0); // R1

  AST_OE_HOLDS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(pin_oe)); // R3

  AST_OUT_HOLDS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(pin_out)); // R3

  AST_UNGATED_VALUE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pin_out & ~$past(gate_all)) == ($past(pin_out) & ~$past(gate_all)))); // R4

  AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[OFF_W-1:0] == OFF_CLR) |-> (bus_rdata == 32'h0)); // R9

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien_all != '0)); // R10
endmodule

bind gpio_banked_ctrl gpio_banked_ctrl_chk #(.BANKS(BANKS), .PPB(PPB)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq       (irq),
  .gate_all  (gate_all),
  .ien_all   (ien_all)
);

// File: tb/gpio_banked_ctrl_test.sv
module gpio_banked_ctrl_test;
  logic         clk;
  logic         rst_n;
  logic [10:0]  bus_addr;
  logic         bus_we;
  logic [31:0]  bus_wdata;
  logic [31:0]  bus_rdata;
  logic [255:0] pin_in;
  logic [255:0] pin_out;
  logic [255:0] pin_oe;
  logic         irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  gpio_banked_ctrl uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {we, addr, wdata, expected read}; bank 3 base 0x180, bank 5 base 0x280
  localparam logic [75:0] TBL [13] = '{
    {1'b1, 11'h184, 32'h0000_00FF, 32'h0},
    {1'b1, 11'h188, 32'h0000_0F0F, 32'h0},
    {1'b1, 11'h180, 32'h0000_FFFF, 32'h0},
    {1'b0, 11'h180, 32'h0,         32'h0000_000F},
    {1'b1, 11'h184, 32'h0000_FFFF, 32'h0},
    {1'b0, 11'h180, 32'h0,         32'h0000_000F},
    {1'b0, 11'h188, 32'h0,         32'h0000_0F0F},
    {1'b1, 11'h188, 32'hABCD_1234, 32'h0},
    {1'b0, 11'h188, 32'h0,         32'h0000_1234},
    {1'b0, 11'h180, 32'h0,         32'h0000_0034},
    {1'b0, 11'h1A4, 32'h0,         32'h0},
    {1'b0, 11'h1AC, 32'h0,         32'h0},
    {1'b0, 11'h288, 32'h0,         32'h0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_we    = 1'b1;
    bus_wdata = d;
    @(negedge clk);
    bus_we    = 1'b0;
    bus_wdata = '0;
  endtask

  task automatic rd(input logic [10:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_we   = 1'b0;
    #1;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n     = 1'b0;
    bus_addr  = '0;
    bus_we    = 1'b0;
    bus_wdata = '0;
    pin_in    = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R2: reset state
    check("R2 pin_oe", pin_oe[31:0] | pin_oe[255:224], 32'h0);
    check("R2 irq", {31'h0, irq}, 32'h0);
    rd(11'h01C, v); check("R2 raw bank0", v, 32'h0);
    rd(11'h788, v); check("R2 oen bank15", v, 32'h0);

    // R1 R3 R4: vector table
    foreach (TBL[i]) begin
      if (TBL[i][75]) wr(TBL[i][74:64], TBL[i][63:32]);
      else begin
        rd(TBL[i][74:64], v);
        check($sformatf("R1/R4 table row %0d", i), v, TBL[i][31:0]);
      end
    end
    check("R3 pin_oe bank3", {16'h0, pin_oe[63:48]}, 32'h1234);
    check("R3 pin_out bank3", {16'h0, pin_out[63:48]}, 32'h00FF);
    check("R1 other bank oe", {16'h0, pin_oe[95:80]}, 32'h0);

    // R5: input sampling in bank 0
    wr(11'h004, 32'hFFFF);
    wr(11'h028, 32'h0001);
    pin_in[1:0] = 2'b11;
    settle();
    rd(11'h000, v); check("R5 sampled input", v, 32'h0001);

    // R6: rising edge on pin 2
    wr(11'h014, 32'h0004);
    wr(11'h024, 32'hFFFF);
    pin_in[2] = 1'b1;
    settle();
    rd(11'h01C, v); check("R6 rise latched", v, 32'h0004);
    check("R10 irq masked", {31'h0, irq}, 32'h0);
    wr(11'h018, 32'h0004);
    check("R10 irq raised", {31'h0, irq}, 32'h1);
    rd(11'h020, v); check("R10 pending", v, 32'h0004);
    wr(11'h024, 32'h0000);
    rd(11'h01C, v); check("R9 zero clear kept", v, 32'h0004);
    wr(11'h024, 32'h0004);
    rd(11'h01C, v); check("R9 one clears", v, 32'h0);
    check("R10 irq dropped", {31'h0, irq}, 32'h0);
    pin_in[2] = 1'b0;
    settle();
    rd(11'h01C, v); check("R6 fall ignored", v, 32'h0);

    // R6: falling polarity on pin 3
    pin_in[3] = 1'b1;
    settle();
    rd(11'h01C, v); check("R6 rise ignored pol0", v, 32'h0);
    pin_in[3] = 1'b0;
    settle();
    rd(11'h01C, v); check("R6 fall latched", v, 32'h0008);
    wr(11'h024, 32'h0008);

    // R7: both edges on pin 4
    wr(11'h014, 32'h0014);
    wr(11'h010, 32'h0010);
    pin_in[4] = 1'b1;
    settle();
    rd(11'h01C, v); check("R7 both rise", v, 32'h0010);
    wr(11'h024, 32'h0010);
    pin_in[4] = 1'b0;
    settle();
    rd(11'h01C, v); check("R7 both fall", v, 32'h0010);
    wr(11'h024, 32'h0010);

    // R8: level sensing on pin 5 (low active first)
    wr(11'h00C, 32'h0020);
    rd(11'h01C, v); check("R8 low level", v, 32'h0020);
    wr(11'h024, 32'h0020);
    rd(11'h01C, v); check("R8 clear no effect", v, 32'h0020);
    pin_in[5] = 1'b1;
    settle();
    rd(11'h01C, v); check("R8 level gone", v, 32'h0);
    wr(11'h014, 32'h0034);
    rd(11'h01C, v); check("R8 high level", v, 32'h0020);
    wr(11'h00C, 32'h0000);
    rd(11'h01C, v); check("R8 no latch while level", v, 32'h0);

    // R10: last bank alone raises the parent line
    wr(11'h798, 32'h8000);
    wr(11'h794, 32'h8000);
    wr(11'h7A4, 32'hFFFF);
    check("R10 idle", {31'h0, irq}, 32'h0);
    pin_in[255] = 1'b1;
    settle();
    check("R10 bank15 irq", {31'h0, irq}, 32'h1);
    rd(11'h7A0, v); check("R10 bank15 pending", v, 32'h8000);
    rd(11'h020, v); check("R10 bank0 quiet", v, 32'h0);
    rd(11'h7A4, v); check("R9 clear reads zero", v, 32'h0);
    wr(11'h7A4, 32'h8000);
    check("R10 bank15 cleared", {31'h0, irq}, 32'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule